// File: doc/BRIEF.md
# Mode-Selectable Dot-Product Schedule Sequencer

This block runs one three-element dot-product instruction at a time. It does so by issuing start pulses to a fixed set of arithmetic unit slots and waiting for their done pulses. The slots are:

- a two-input adder
- a three-input adder
- two slow multipliers
- three fast multipliers
- a dedicated dot-product unit

A 3-bit schedule code, kept apart from the opcode, picks how the same instruction is spread over those units. The choices are lowest latency, lowest peak power, the dedicated unit, a resource-limited plan on the two slow multipliers, and a balanced plan that mixes one fast and one slow multiplier.

The sequencer produces no data of its own. Alongside every start pulse it drives operand-select codes. A multiplier's code names the vector element whose pair of operands it multiplies. The two-input adder's codes name which stored products, or the running partial sum, it should add.

States of the controller:

| State | Role | Exit |
|---|---|---|
| `ST_IDLE` | Waits for a request. | Goes to the first state of the chosen plan, or to `ST_FIN` for an unused code. |
| `ST_DOT` | Runs the dedicated dot-product unit. | — |
| `ST_FA_MUL`, `ST_FA_SUM` | Fast plan: products, then the three-input sum. | — |
| `ST_LP_M0`, `ST_LP_M1`, `ST_LP_M2`, `ST_LP_SUM` | Low-power plan: three products one after another, then the three-input sum. | — |
| `ST_RL_MUL`, `ST_RL_MIX`, `ST_RL_ACC` | Resource-limited plan. | — |
| `ST_BL_PAIR`, `ST_BL_FAST2`, `ST_BL_ADD`, `ST_BL_ACC` | Balanced plan. | — |
| `ST_FIN` | Raises done for one cycle. | Always returns to `ST_IDLE`. |

Every working state launches its units in the cycle it is entered. It then waits on its own list of units and steps to the next state in the cycle the last awaited done pulse arrives.

Top module: `dotsched_seq`

## Requirements
- R1: Schedule code 000 starts only the dot-product unit (unit bit 7), once, and no other unit.
- R2: Code 001 starts fast multipliers 0, 1 and 2 in one cycle with element selects 0, 1 and 2. It starts the three-input adder (unit bit 1) only after all three fast multipliers have returned done.
- R3: Code 011 uses slow multiplier 0 alone for elements 0, 1 and 2, in that order, each start after the previous done. It then starts the three-input adder.
- R4: Code 111 first starts both slow multipliers together on elements 0 and 1. It then starts, in one cycle, the two-input adder on products 0 and 1 and slow multiplier 0 on element 2. Last, it starts the two-input adder on the partial sum and product 2.
- R5: Code 101 first starts fast multiplier 0 on element 0 and slow multiplier 0 on element 2 together. Next it starts fast multiplier 0 on element 1. Then it starts the two-input adder on products 0 and 1, and finally the two-input adder on the partial sum and product 2.
- R6: Codes 010, 100 and 110 start no unit; done and fault are high together in the cycle after the request.
- R7: For a valid code, done is a one-cycle pulse in the cycle right after the done of the last adder (or of the dot-product unit), with fault low, and no unit is still running.
- R8: No unit receives a start while it has one outstanding without a done.
- R9: The request and schedule code are taken only in `ST_IDLE`; requests and code changes while an instruction runs alter neither its schedule nor the number of done pulses.
- R10: Unit bit order is two-input adder 0, three-input adder 1, slow multipliers 2–3, fast multipliers 4–6, dot-product 7. Start pulses last one cycle. Multiplier selects hold the element index 0..2. Two-input adder sources use 0..2 for products and 3 for the partial sum. Every select reads 0 except in the cycle its unit starts.
- R11: Out of reset, no start, done or fault is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Instruction request, taken in idle |
| mode_i | input | 3 | Schedule code |
| unit_done_i | input | 8 | Per-unit completion pulses |
| unit_start_o | output | 8 | Per-unit start pulses |
| smul_sel_o | output | 4 | Element selects of slow multipliers 0 and 1 |
| fmul_sel_o | output | 6 | Element selects of fast multipliers 0..2 |
| add2_sel_a_o | output | 2 | First source of the two-input adder |
| add2_sel_b_o | output | 2 | Second source of the two-input adder |
| done_o | output | 1 | Instruction finished |
| fault_o | output | 1 | Unused schedule code, valid with done |

## Verification
The bench builds the block with its package constants and wraps each unit in a latency stub. Stub latencies are drawn per start: one to three cycles for adders, three to six for slow multipliers, one to two for fast multipliers, and two to five for the dot-product unit. Those ranges bring within reach the cases where the slow multiplier in the balanced plan finishes before or after the first addition becomes ready, and where the mixed step of the resource-limited plan completes in either order. Product-ready tracking checks each adder start against its operands, and request noise during runs probes the sampling rule.

// File: rtl/dotsched_pkg.sv
package dotsched_pkg;
    localparam int N_UNITS = 8;
    localparam int N_SLOW  = 2;
    localparam int N_FAST  = 3;
    localparam int SEL_W   = 2;
    localparam int MODE_W  = 3;

    localparam int U_ADD2 = 0;
    localparam int U_ADD3 = 1;
    localparam int U_SM0  = 2;
    localparam int U_SM1  = 3;
    localparam int U_FM0  = 4;
    localparam int U_FM1  = 5;
    localparam int U_FM2  = 6;
    localparam int U_DOT  = 7;

    localparam logic [SEL_W-1:0] SRC_PSUM = 2'd3;

    localparam logic [MODE_W-1:0] MC_DOT    = 3'b000;
    localparam logic [MODE_W-1:0] MC_FAST   = 3'b001;
    localparam logic [MODE_W-1:0] MC_LOWPWR = 3'b011;
    localparam logic [MODE_W-1:0] MC_BAL    = 3'b101;
    localparam logic [MODE_W-1:0] MC_RESLIM = 3'b111;

    typedef logic [N_UNITS-1:0] umask_t;

    typedef enum logic [2:0] {
        SCH_DOT, SCH_FAST, SCH_LOWPWR, SCH_RESLIM, SCH_BAL, SCH_BAD
    } sched_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DOT,
        ST_FA_MUL, ST_FA_SUM,
        ST_LP_M0, ST_LP_M1, ST_LP_M2, ST_LP_SUM,
        ST_RL_MUL, ST_RL_MIX, ST_RL_ACC,
        ST_BL_PAIR, ST_BL_FAST2, ST_BL_ADD, ST_BL_ACC,
        ST_FIN
    } state_e;

    function automatic umask_t ubit(input int u);
        return umask_t'(1) << u;
    endfunction
endpackage

// File: rtl/dotsched_mode_dec.sv
module dotsched_mode_dec
    import dotsched_pkg::*;
(
    input  logic [MODE_W-1:0] code_i,
    output sched_e            sched_o
);
    always_comb begin
        unique case (code_i)
            MC_DOT:    sched_o = SCH_DOT;
            MC_FAST:   sched_o = SCH_FAST;
            MC_LOWPWR: sched_o = SCH_LOWPWR;
            MC_RESLIM: sched_o = SCH_RESLIM;
            MC_BAL:    sched_o = SCH_BAL;
            default:   sched_o = SCH_BAD;
        endcase
    end
endmodule

// File: rtl/dotsched_busy.sv
module dotsched_busy
    import dotsched_pkg::*;
#(
    parameter int N = N_UNITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] start_i,
    input  logic [N-1:0] done_i,
    output logic [N-1:0] busy_o,
    output logic [N-1:0] pending_o
);
    for (genvar u = 0; u < N; u++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                busy_o[u] <= 1'b0;
            else if (start_i[u])
                busy_o[u] <= 1'b1;
            else if (done_i[u])
                busy_o[u] <= 1'b0;
        end

        assign pending_o[u] = busy_o[u] & ~done_i[u];

        // R8: a slot is never started while its previous start is unanswered
        assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
            start_i[u] |-> !busy_o[u]);
    end
endmodule

// File: rtl/dotsched_seq.sv
module dotsched_seq
    import dotsched_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [MODE_W-1:0]         mode_i,
    input  logic [N_UNITS-1:0]        unit_done_i,
    output logic [N_UNITS-1:0]        unit_start_o,
    output logic [N_SLOW*SEL_W-1:0]   smul_sel_o,
    output logic [N_FAST*SEL_W-1:0]   fmul_sel_o,
    output logic [SEL_W-1:0]          add2_sel_a_o,
    output logic [SEL_W-1:0]          add2_sel_b_o,
    output logic                      done_o,
    output logic                      fault_o
);
    localparam umask_t FINAL_UNITS = ubit(U_ADD2) | ubit(U_ADD3) | ubit(U_DOT);

    state_e state, nxt, entry;
    logic   fresh;
    logic   fault_q;
    sched_e sched;

    umask_t launch, waitm, busy, pending;
    logic [N_SLOW-1:0][SEL_W-1:0] sm_sel;
    logic [N_FAST-1:0][SEL_W-1:0] fm_sel;
    logic [SEL_W-1:0] a_sel, b_sel;
    logic step_ok;

    dotsched_mode_dec u_dec (
        .code_i  (mode_i),
        .sched_o (sched)
    );

    dotsched_busy #(.N(N_UNITS)) u_busy (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (unit_start_o),
        .done_i    (unit_done_i),
        .busy_o    (busy),
        .pending_o (pending)
    );

    // entry state of each plan
    always_comb begin
        unique case (sched)
            SCH_DOT:    entry = ST_DOT;
            SCH_FAST:   entry = ST_FA_MUL;
            SCH_LOWPWR: entry = ST_LP_M0;
            SCH_RESLIM: entry = ST_RL_MUL;
            SCH_BAL:    entry = ST_BL_PAIR;
            default:    entry = ST_FIN;
        endcase
    end

    // per-state launch set, wait set, selects and successor
    always_comb begin
        launch = '0;
        waitm  = '0;
        sm_sel = '0;
        fm_sel = '0;
        a_sel  = '0;
        b_sel  = '0;
        nxt    = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_FIN: nxt = ST_IDLE;
            ST_DOT: begin
                launch = ubit(U_DOT);
                waitm  = ubit(U_DOT);
                nxt    = ST_FIN;
            end
            ST_FA_MUL: begin
                launch    = ubit(U_FM0) | ubit(U_FM1) | ubit(U_FM2);
                waitm     = launch;
                fm_sel[0] = 2'd0;
                fm_sel[1] = 2'd1;
                fm_sel[2] = 2'd2;
                nxt       = ST_FA_SUM;
            end
            ST_FA_SUM, ST_LP_SUM: begin
                launch = ubit(U_ADD3);
                waitm  = ubit(U_ADD3);
                nxt    = ST_FIN;
            end
            ST_LP_M0: begin
                launch    = ubit(U_SM0);
                waitm     = launch;
                sm_sel[0] = 2'd0;
                nxt       = ST_LP_M1;
            end
            ST_LP_M1: begin
                launch    = ubit(U_SM0);
                waitm     = launch;
                sm_sel[0] = 2'd1;
                nxt       = ST_LP_M2;
            end
            ST_LP_M2: begin
                launch    = ubit(U_SM0);
                waitm     = launch;
                sm_sel[0] = 2'd2;
                nxt       = ST_LP_SUM;
            end
            ST_RL_MUL: begin
                launch    = ubit(U_SM0) | ubit(U_SM1);
                waitm     = launch;
                sm_sel[0] = 2'd0;
                sm_sel[1] = 2'd1;
                nxt       = ST_RL_MIX;
            end
            ST_RL_MIX: begin
                launch    = ubit(U_ADD2) | ubit(U_SM0);
                waitm     = launch;
                sm_sel[0] = 2'd2;
                a_sel     = 2'd0;
                b_sel     = 2'd1;
                nxt       = ST_RL_ACC;
            end
            ST_RL_ACC, ST_BL_ACC: begin
                launch = ubit(U_ADD2);
                waitm  = ubit(U_ADD2);
                a_sel  = SRC_PSUM;
                b_sel  = 2'd2;
                nxt    = ST_FIN;
            end
            ST_BL_PAIR: begin
                launch    = ubit(U_FM0) | ubit(U_SM0);
                waitm     = ubit(U_FM0);
                fm_sel[0] = 2'd0;
                sm_sel[0] = 2'd2;
                nxt       = ST_BL_FAST2;
            end
            ST_BL_FAST2: begin
                launch    = ubit(U_FM0);
                waitm     = ubit(U_FM0);
                fm_sel[0] = 2'd1;
                nxt       = ST_BL_ADD;
            end
            ST_BL_ADD: begin
                launch = ubit(U_ADD2);
                waitm  = ubit(U_ADD2) | ubit(U_SM0);
                a_sel  = 2'd0;
                b_sel  = 2'd1;
                nxt    = ST_BL_ACC;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign step_ok = !fresh && ((pending & waitm) == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            fresh   <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            fresh <= 1'b0;
            if (state == ST_IDLE) begin
                if (start_i) begin
                    state   <= entry;
                    fresh   <= 1'b1;
                    fault_q <= (sched == SCH_BAD);
                end
            end else if (state == ST_FIN) begin
                state <= ST_IDLE;
            end else if (step_ok) begin
                state <= nxt;
                fresh <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unit_start_o = fresh ? launch : '0;
        smul_sel_o   = fresh ? sm_sel : '0;
        fmul_sel_o   = fresh ? fm_sel : '0;
        add2_sel_a_o = fresh ? a_sel  : '0;
        add2_sel_b_o = fresh ? b_sel  : '0;
        done_o       = (state == ST_FIN);
        fault_o      = (state == ST_FIN) && fault_q;
    end

    // R7: done lasts exactly one cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7: a clean finish follows a done from an adder or the dot-product unit
    assert_done_after_final_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o) |-> (($past(unit_done_i) & FINAL_UNITS) != '0));
    // R6: a fault is only reported with done, right after an accepted request
    assert_fault_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (done_o && $past(start_i) && $past(state == ST_IDLE)));
    // R10: starts and done never overlap, and starts never repeat back to back
    assert_start_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_start_o != '0) |-> (!done_o && ((busy & unit_start_o) == '0)));
endmodule

// File: tb/sim_dotsched_seq.sv
module sim_dotsched_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] mode_i = 3'b000;
    logic [7:0] unit_done_i = 8'h00;
    logic [7:0] unit_start_o;
    logic [3:0] smul_sel_o;
    logic [5:0] fmul_sel_o;
    logic [1:0] add2_sel_a_o, add2_sel_b_o;
    logic       done_o, fault_o;

    always #4 clk = ~clk;

    dotsched_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .unit_done_i(unit_done_i), .unit_start_o(unit_start_o),
        .smul_sel_o(smul_sel_o), .fmul_sel_o(fmul_sel_o),
        .add2_sel_a_o(add2_sel_a_o), .add2_sel_b_o(add2_sel_b_o),
        .done_o(done_o), .fault_o(fault_o)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_bad(input logic [2:0] m);
        return (m == 3'b010) || (m == 3'b100) || (m == 3'b110);
    endfunction

    function automatic string mtag(input logic [2:0] m);
        case (m)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b011:  return "R3";
            3'b111:  return "R4";
            3'b101:  return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [21:0] pk(input logic [7:0] m, input logic [1:0] sm0, sm1,
                                       fm0, fm1, fm2, a, b);
        return {m, a, b, fm2, fm1, fm0, sm1, sm0};
    endfunction

    function automatic int exp_n(input logic [2:0] m);
        case (m)
            3'b000:  return 1;
            3'b001:  return 2;
            3'b011:  return 4;
            3'b111:  return 3;
            3'b101:  return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [21:0] exp_grp(input logic [2:0] m, input int i);
        case (m)
            3'b000: return pk(8'h80, 0, 0, 0, 0, 0, 0, 0);
            3'b001: return (i == 0) ? pk(8'h70, 0, 0, 0, 1, 2, 0, 0)
                                    : pk(8'h02, 0, 0, 0, 0, 0, 0, 0);
            3'b011: return (i < 3) ? pk(8'h04, 2'(i), 0, 0, 0, 0, 0, 0)
                                   : pk(8'h02, 0, 0, 0, 0, 0, 0, 0);
            3'b111: begin
                if (i == 0) return pk(8'h0C, 0, 1, 0, 0, 0, 0, 0);
                if (i == 1) return pk(8'h05, 2, 0, 0, 0, 0, 0, 1);
                return pk(8'h01, 0, 0, 0, 0, 0, 3, 2);
            end
            3'b101: begin
                if (i == 0) return pk(8'h14, 2, 0, 0, 0, 0, 0, 0);
                if (i == 1) return pk(8'h10, 0, 0, 1, 0, 0, 0, 0);
                if (i == 2) return pk(8'h01, 0, 0, 0, 0, 0, 0, 1);
                return pk(8'h01, 0, 0, 0, 0, 0, 3, 2);
            end
            default: return '0;
        endcase
    endfunction

    function automatic int lat(input int u);
        if (u <= 1) return int'($urandom_range(3, 1));
        if (u <= 3) return int'($urandom_range(6, 3));
        if (u <= 6) return int'($urandom_range(2, 1));
        return int'($urandom_range(5, 2));
    endfunction

    // state shared between driver and monitor
    logic [2:0] cur_mode = 3'b000;
    int issue_cyc = 0;

    // stubs and monitor
    int cnt [8];
    logic [1:0] lsel [8];
    logic [2:0] prod_rdy = 3'b000;
    bit psum_rdy = 0;
    int fin_cyc = 0;
    logic [21:0] grp [8];
    int ngrp = 0;
    bit prev_done = 0;

    initial for (int u = 0; u < 8; u++) begin cnt[u] = 0; lsel[u] = 2'd0; end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            unit_done_i = 8'h00;
            for (int u = 0; u < 8; u++) begin
                if (cnt[u] > 0) begin
                    cnt[u]--;
                    if (cnt[u] == 0) begin
                        unit_done_i[u] = 1'b1;
                        if (u >= 2 && u <= 6) prod_rdy[lsel[u]] = 1'b1;
                        if (u == 0) psum_rdy = 1;
                        if (u == 0 || u == 1 || u == 7) fin_cyc = cyc;
                    end
                end
            end
            // R10: selects stay zero unless their unit is being started
            chk(((unit_start_o[2] ? 2'd0 : smul_sel_o[1:0]) |
                 (unit_start_o[3] ? 2'd0 : smul_sel_o[3:2]) |
                 (unit_start_o[4] ? 2'd0 : fmul_sel_o[1:0]) |
                 (unit_start_o[5] ? 2'd0 : fmul_sel_o[3:2]) |
                 (unit_start_o[6] ? 2'd0 : fmul_sel_o[5:4]) |
                 (unit_start_o[0] ? 2'd0 : (add2_sel_a_o | add2_sel_b_o))) == 2'd0,
                "R10", "idle select", {smul_sel_o, fmul_sel_o}, 0);
            for (int u = 0; u < 8; u++) begin
                if (unit_start_o[u]) begin
                    chk(cnt[u] == 0, "R8", "restart of busy unit", u, 0);
                    if (u == 1)
                        chk(prod_rdy == 3'b111, mtag(cur_mode), "3-input add before products",
                            prod_rdy, 7);
                    if (u == 0) begin
                        chk((add2_sel_a_o == 2'd3) ? psum_rdy : prod_rdy[add2_sel_a_o],
                            mtag(cur_mode), "2-input add source A not ready", add2_sel_a_o, 1);
                        chk((add2_sel_b_o == 2'd3) ? psum_rdy : prod_rdy[add2_sel_b_o],
                            mtag(cur_mode), "2-input add source B not ready", add2_sel_b_o, 1);
                    end
                    cnt[u] = lat(u);
                    if (u == 2) lsel[u] = smul_sel_o[1:0];
                    if (u == 3) lsel[u] = smul_sel_o[3:2];
                    if (u >= 4 && u <= 6) lsel[u] = fmul_sel_o[2*(u-4) +: 2];
                end
            end
            if (unit_start_o != 8'h00) begin
                if (ngrp < 8)
                    grp[ngrp] = {unit_start_o, add2_sel_a_o, add2_sel_b_o, fmul_sel_o, smul_sel_o};
                ngrp++;
            end
            if (done_o) begin
                chk(!prev_done, "R7", "done longer than one cycle", 1, 0);
                chk(fault_o == is_bad(cur_mode), is_bad(cur_mode) ? "R6" : "R7",
                    "fault flag", fault_o, is_bad(cur_mode));
                if (is_bad(cur_mode))
                    chk(cyc == issue_cyc + 1, "R6", "done cycle", cyc, issue_cyc + 1);
                else
                    chk(cyc == fin_cyc + 1, "R7", "done cycle", cyc, fin_cyc + 1);
                chk(ngrp == exp_n(cur_mode), mtag(cur_mode), "launch step count",
                    ngrp, exp_n(cur_mode));
                for (int i = 0; i < 8; i++)
                    if (i < ngrp && i < exp_n(cur_mode))
                        chk(grp[i] == exp_grp(cur_mode, i), mtag(cur_mode), "launch step",
                            grp[i], exp_grp(cur_mode, i));
                for (int u = 0; u < 8; u++)
                    chk(cnt[u] == 0, "R7", "unit running at done", u, 0);
                ngrp = 0;
                prod_rdy = 3'b000;
                psum_rdy = 0;
            end
            prev_done = done_o;
        end
    end

    task automatic summary();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            chk(0, "R7", "watchdog expired", cyc, 150000);
            summary();
        end
    end

    task automatic run(input logic [2:0] m);
        @(negedge clk);
        start_i = 1'b1;
        mode_i = m;
        cur_mode = m;
        issue_cyc = cyc;
        @(negedge clk);
        while (!done_o) begin
            // R9: noise on request and code while busy
            start_i = 1'($urandom_range(1, 0));
            mode_i = 3'($urandom_range(7, 0));
            @(negedge clk);
        end
        start_i = 1'b0;
        mode_i = 3'($urandom_range(7, 0));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!done_o && unit_start_o == 8'h00, "R9", "activity after finish",
                {done_o, unit_start_o}, 0);
        end
    endtask

    initial begin
        logic [2:0] directed [8];
        void'($urandom(32'd20240611));
        directed = '{3'b000, 3'b001, 3'b011, 3'b111, 3'b101, 3'b010, 3'b100, 3'b110};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(unit_start_o == 8'h00 && !done_o && !fault_o, "R11", "reset state",
            {unit_start_o, done_o, fault_o}, 0);
        for (int i = 0; i < 8; i++) run(directed[i]);
        for (int i = 0; i < 80; i++) run(3'($urandom_range(7, 0)));
        summary();
    end
endmodule